// File: doc/BRIEF.md
# Binary-Tree Power Level Arbiter Node

This block sits at an interior position of a binary tree that hands out power levels to compute resources. It holds the committed level of its left and right children and, toward its own parent, acts like one leaf whose level is the rounded-up mean of the two child levels. A child asks for a new level. If granting that level keeps the node's mean level the same, the node answers the child directly. Otherwise it asks its parent for the new mean level and passes the parent's verdict down to the child. The node never allows both children to sit at the top level.

Every answer to a child ends in an acknowledge handshake before the new level is committed. While a request is open, the node accepts no other request. An optional split mode can be enabled by a mode input when the left child is at the bottom level and the right child is at the top level. In that mode the node still reports the middle level upward, but it refuses any left request for the two highest levels.

Top module: `ptn_node`

## Requirements
- R1: After synchronous active-high reset, both committed child levels and the node level read Low (code 0), and no request, response or acknowledge output is active.
- R2: Levels are coded Low=0, Medium-Low=1, Medium=2, Medium-High=3, High=4. The node level output equals (left+right+1)/2 (integer division) of the committed child levels. Input codes above 4 are treated as High.
- R3: When a child's requested level leaves the node mean unchanged, the child receives a grant (response valid with grant=1) one cycle after its request is sampled, and no parent request is raised.
- R4: When the requested level would change the node mean, the node raises its parent request with the new mean level. It holds that request and its level steady until the parent responds.
- R5: On a parent grant, the node pulses the child response with grant=1 and the parent acknowledge in the same cycle. The new child level is committed only when the acknowledge from that child is sampled.
- R6: On a parent deny, the node pulses the child response with grant=0 together with the parent acknowledge. Both committed levels stay unchanged, and so does the node level.
- R7: A request for High while the other child is committed at High is denied locally, without a parent request. The committed levels stay unchanged.
- R8: While a transaction is open (pending or awaiting a child acknowledge), no other child request is answered and the committed levels do not change. When both children request in the same cycle, the left child is served first.
- R9: When the mode input is high and the committed levels are left=Low and right=High, the split indicator rises. In that state the node level stays Medium, and left requests for Medium-High or High are denied locally. When the mode input is low while idle, the indicator clears and normal handling resumes.
- R10: The committed left and right levels are never both High.
- R11: Requests from the right child are handled by the same rules as those from the left, with the sides swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode_en | input | 1 | Allows entry into the split state when left=Low and right=High |
| l_req_valid | input | 1 | Left child request, held until its response |
| l_req_level | input | 3 | Level asked for by the left child |
| l_resp_valid | output | 1 | One-cycle response pulse to the left child |
| l_resp_grant | output | 1 | 1 = grant, 0 = deny, valid with l_resp_valid |
| l_ack | input | 1 | Left child acknowledge of a response |
| r_req_valid | input | 1 | Right child request, held until its response |
| r_req_level | input | 3 | Level asked for by the right child |
| r_resp_valid | output | 1 | One-cycle response pulse to the right child |
| r_resp_grant | output | 1 | 1 = grant, 0 = deny, valid with r_resp_valid |
| r_ack | input | 1 | Right child acknowledge of a response |
| up_req_valid | output | 1 | Request to the parent, held until the parent responds |
| up_req_level | output | 3 | Node mean level being asked for |
| up_resp_valid | input | 1 | One-cycle parent response pulse |
| up_resp_grant | input | 1 | Parent verdict, 1 = grant |
| up_ack | output | 1 | Acknowledge pulse to the parent |
| left_level | output | 3 | Committed left child level |
| right_level | output | 3 | Committed right child level |
| node_level | output | 3 | Rounded-up mean of the committed child levels |
| split_active | output | 1 | Split state indicator |

## Verification
Random requests from either side are checked against a bench model of the mean-level rule, with random parent verdicts. These show whether the block correctly separates local grants, local denials and forwarded requests, and whether the forwarded level is the right mean. Directed sequences cover the remaining cases. Simultaneous requests show the left-first ordering and the stall of the other side. Reaching left=Low/right=High with the mode input high shows that the split state denies high left requests while the node level stays Medium. A parent deny shows that nothing is committed. A High request against a High sibling shows the local refusal, and a per-cycle monitor keeps watch on the both-High invariant.

// File: rtl/ptn_pkg.sv
package ptn_pkg;

    localparam int LVL_W   = 3;
    localparam int LVL_MAX = 4;

    typedef enum logic [LVL_W-1:0] {
        LV_L  = 3'd0,
        LV_ML = 3'd1,
        LV_M  = 3'd2,
        LV_MH = 3'd3,
        LV_H  = 3'd4
    } lvl_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_LOCAL_GRANT,
        ACT_LOCAL_DENY,
        ACT_FORWARD
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_BLOCK
    } st_e;

    // side: 0 = left, 1 = right
    typedef struct packed {
        logic valid;
        logic side;
        lvl_e lvl;
    } creq_t;

    function automatic lvl_e lvl_clip(input logic [LVL_W-1:0] v);
        if (int'(v) > LVL_MAX) return LV_H;
        return lvl_e'(v);
    endfunction

    function automatic lvl_e lvl_avg(input lvl_e a, input lvl_e b);
        logic [LVL_W:0] s;
        s = {1'b0, a} + {1'b0, b} + {{LVL_W{1'b0}}, 1'b1};
        return lvl_e'(s[LVL_W:1]);
    endfunction

endpackage

// File: rtl/ptn_req_pick.sv
module ptn_req_pick
    import ptn_pkg::*;
#(
    parameter int N_SIDE = 2
) (
    input  logic                       enable,
    input  logic [N_SIDE-1:0]          valid,
    input  logic [N_SIDE*LVL_W-1:0]    levels,
    output creq_t                      pick
);
    localparam int SEL_W = (N_SIDE > 1) ? $clog2(N_SIDE) : 1;

    // lowest index (left) wins
    logic [N_SIDE-1:0] higher_taken;
    logic [N_SIDE-1:0] grant_vec;

    genvar g;
    generate
        for (g = 0; g < N_SIDE; g++) begin : g_prio
            if (g == 0) begin : g_first
                assign higher_taken[g] = 1'b0;
            end else begin : g_rest
                assign higher_taken[g] = higher_taken[g-1] | valid[g-1];
            end
            assign grant_vec[g] = enable & valid[g] & ~higher_taken[g];
        end
    endgenerate

    always_comb begin
        logic [SEL_W-1:0] sel;
        sel = '0;
        for (int i = 0; i < N_SIDE; i++) begin
            if (grant_vec[i]) sel = SEL_W'(i);
        end
        pick.valid = |grant_vec;
        pick.side  = sel[0];
        pick.lvl   = lvl_clip(levels[int'(sel)*LVL_W +: LVL_W]);
    end

endmodule

// File: rtl/ptn_decide.sv
module ptn_decide
    import ptn_pkg::*;
(
    input  creq_t req,
    input  lvl_e  lvl_left,
    input  lvl_e  lvl_right,
    input  logic  split_on,
    output act_e  act,
    output lvl_e  new_mean
);
    lvl_e other_lvl;
    lvl_e nl, nr;
    lvl_e old_mean;

    always_comb begin
        other_lvl = req.side ? lvl_left : lvl_right;
        nl        = req.side ? lvl_left : req.lvl;
        nr        = req.side ? req.lvl  : lvl_right;
        old_mean  = lvl_avg(lvl_left, lvl_right);
        new_mean  = lvl_avg(nl, nr);

        if (!req.valid) begin
            act = ACT_NONE;
        end else if (req.lvl == LV_H && other_lvl == LV_H) begin
            act = ACT_LOCAL_DENY;
        end else if (split_on && !req.side && (req.lvl == LV_MH || req.lvl == LV_H)) begin
            act = ACT_LOCAL_DENY;
        end else if (new_mean == old_mean) begin
            act = ACT_LOCAL_GRANT;
        end else begin
            act = ACT_FORWARD;
        end
    end

endmodule

// File: rtl/ptn_level_store.sv
module ptn_level_store
    import ptn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic split_mode_en,
    input  logic commit,
    input  logic commit_side,
    input  lvl_e commit_lvl,
    output lvl_e lvl_left,
    output lvl_e lvl_right,
    output lvl_e node_lvl,
    output logic split_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_left  <= LV_L;
            lvl_right <= LV_L;
            split_on  <= 1'b0;
        end else begin
            if (commit) begin
                if (commit_side) lvl_right <= commit_lvl;
                else             lvl_left  <= commit_lvl;
                split_on <= 1'b0;
            end else if (idle) begin
                split_on <= split_mode_en && lvl_left == LV_L && lvl_right == LV_H;
            end
        end
    end

    assign node_lvl = lvl_avg(lvl_left, lvl_right);

    a_r10_never_both_high: assert property (@(posedge clk) disable iff (rst)
        !(lvl_left == LV_H && lvl_right == LV_H));

    a_r9_split_only_low_high: assert property (@(posedge clk) disable iff (rst)
        split_on |-> (lvl_left == LV_L && lvl_right == LV_H));

endmodule

// File: rtl/ptn_node.sv
module ptn_node
    import ptn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       split_mode_en,
    input  logic       l_req_valid,
    input  logic [2:0] l_req_level,
    output logic       l_resp_valid,
    output logic       l_resp_grant,
    input  logic       l_ack,
    input  logic       r_req_valid,
    input  logic [2:0] r_req_level,
    output logic       r_resp_valid,
    output logic       r_resp_grant,
    input  logic       r_ack,
    output logic       up_req_valid,
    output logic [2:0] up_req_level,
    input  logic       up_resp_valid,
    input  logic       up_resp_grant,
    output logic       up_ack,
    output logic [2:0] left_level,
    output logic [2:0] right_level,
    output logic [2:0] node_level,
    output logic       split_active
);
    st_e   st_q;
    logic  side_q;
    lvl_e  want_q;
    lvl_e  up_lvl_q;
    logic  grant_q;
    logic  l_resp_q, r_resp_q, up_ack_q;

    creq_t pick;
    act_e  act;
    lvl_e  new_mean;
    lvl_e  lvl_l, lvl_r, node_lvl;
    logic  split_on;
    logic  side_ack;
    logic  commit;

    ptn_req_pick #(.N_SIDE(2)) u_pick (
        .enable (st_q == ST_IDLE),
        .valid  ({r_req_valid, l_req_valid}),
        .levels ({r_req_level, l_req_level}),
        .pick   (pick)
    );

    ptn_decide u_decide (
        .req       (pick),
        .lvl_left  (lvl_l),
        .lvl_right (lvl_r),
        .split_on  (split_on),
        .act       (act),
        .new_mean  (new_mean)
    );

    assign side_ack = side_q ? r_ack : l_ack;
    assign commit   = (st_q == ST_BLOCK) && side_ack && grant_q;

    ptn_level_store u_store (
        .clk           (clk),
        .rst           (rst),
        .idle          (st_q == ST_IDLE),
        .split_mode_en (split_mode_en),
        .commit        (commit),
        .commit_side   (side_q),
        .commit_lvl    (want_q),
        .lvl_left      (lvl_l),
        .lvl_right     (lvl_r),
        .node_lvl      (node_lvl),
        .split_on      (split_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            side_q   <= 1'b0;
            want_q   <= LV_L;
            up_lvl_q <= LV_L;
            grant_q  <= 1'b0;
            l_resp_q <= 1'b0;
            r_resp_q <= 1'b0;
            up_ack_q <= 1'b0;
        end else begin
            l_resp_q <= 1'b0;
            r_resp_q <= 1'b0;
            up_ack_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (act != ACT_NONE) begin
                        side_q <= pick.side;
                        want_q <= pick.lvl;
                        if (act == ACT_FORWARD) begin
                            st_q     <= ST_PEND;
                            up_lvl_q <= new_mean;
                        end else begin
                            st_q     <= ST_BLOCK;
                            grant_q  <= (act == ACT_LOCAL_GRANT);
                            l_resp_q <= !pick.side;
                            r_resp_q <= pick.side;
                        end
                    end
                end
                ST_PEND: begin
                    if (up_resp_valid) begin
                        st_q     <= ST_BLOCK;
                        grant_q  <= up_resp_grant;
                        up_ack_q <= 1'b1;
                        l_resp_q <= !side_q;
                        r_resp_q <= side_q;
                    end
                end
                ST_BLOCK: begin
                    if (side_ack) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign l_resp_valid = l_resp_q;
    assign r_resp_valid = r_resp_q;
    assign l_resp_grant = grant_q;
    assign r_resp_grant = grant_q;
    assign up_req_valid = (st_q == ST_PEND);
    assign up_req_level = up_lvl_q;
    assign up_ack       = up_ack_q;
    assign left_level   = lvl_l;
    assign right_level  = lvl_r;
    assign node_level   = node_lvl;
    assign split_active = split_on;

    a_r4_up_req_held: assert property (@(posedge clk) disable iff (rst)
        (up_req_valid && !up_resp_valid) |=> (up_req_valid && $stable(up_req_level)));

    a_r5_up_ack_after_resp: assert property (@(posedge clk) disable iff (rst)
        up_ack |-> $past(up_resp_valid));

    a_r8_single_resp: assert property (@(posedge clk) disable iff (rst)
        !(l_resp_valid && r_resp_valid));

    a_r8_pend_frozen: assert property (@(posedge clk) disable iff (rst)
        up_req_valid |=> ($stable(left_level) && $stable(right_level)));

    a_r3_resp_waits_ack: assert property (@(posedge clk) disable iff (rst)
        (l_resp_valid || r_resp_valid) |=> ($stable(left_level) || $past(l_ack || r_ack)));

endmodule

// File: tb/tb_ptn_node.sv
`timescale 1ns/1ps
module tb_ptn_node;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic split_mode_en = 1'b0;
    logic l_req_valid = 1'b0, r_req_valid = 1'b0;
    logic [2:0] l_req_level = '0, r_req_level = '0;
    logic l_ack = 1'b0, r_ack = 1'b0;
    logic up_resp_valid = 1'b0, up_resp_grant = 1'b0;
    logic l_resp_valid, l_resp_grant, r_resp_valid, r_resp_grant;
    logic up_req_valid, up_ack, split_active;
    logic [2:0] up_req_level, left_level, right_level, node_level;

    always #2.5 clk = ~clk;

    ptn_node dut (
        .clk(clk), .rst(rst), .split_mode_en(split_mode_en),
        .l_req_valid(l_req_valid), .l_req_level(l_req_level),
        .l_resp_valid(l_resp_valid), .l_resp_grant(l_resp_grant), .l_ack(l_ack),
        .r_req_valid(r_req_valid), .r_req_level(r_req_level),
        .r_resp_valid(r_resp_valid), .r_resp_grant(r_resp_grant), .r_ack(r_ack),
        .up_req_valid(up_req_valid), .up_req_level(up_req_level),
        .up_resp_valid(up_resp_valid), .up_resp_grant(up_resp_grant), .up_ack(up_ack),
        .left_level(left_level), .right_level(right_level),
        .node_level(node_level), .split_active(split_active)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    int m_l = 0, m_r = 0;
    int e_kind, e_up;          // kind: 0 local grant, 1 local deny, 2 forward
    int g_side, g_grant, g_up_lvl;
    bit g_up_seen, g_ack_seen, g_timeout;

    function automatic int mean_of(int a, int b);
        return (a + b + 1) / 2;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // R10 monitor on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (left_level == 3'd4 && right_level == 3'd4) begin
                errors++;
                $display("FAIL R10 both High: actual %0d/%0d expected not 4/4",
                         left_level, right_level);
            end
        end
    end

    task automatic compute_exp(int side, int lvl);
        int own_other, nl, nr;
        bit spl;
        own_other = side ? m_l : m_r;
        nl = side ? m_l : lvl;
        nr = side ? lvl : m_r;
        spl = split_mode_en && m_l == 0 && m_r == 4;
        e_up = mean_of(nl, nr);
        if (lvl == 4 && own_other == 4)                 e_kind = 1;
        else if (spl && side == 0 && lvl >= 3)          e_kind = 1;
        else if (e_up == mean_of(m_l, m_r))             e_kind = 0;
        else                                             e_kind = 2;
    endtask

    // runs until one child response appears, acting as parent
    task automatic serve(bit pgrant);
        bit sent;
        sent = 0;
        g_up_seen = 0; g_ack_seen = 0; g_timeout = 0; g_up_lvl = -1;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            up_resp_valid = 1'b0;
            if (up_ack) g_ack_seen = 1;
            if (l_resp_valid || r_resp_valid) begin
                g_side  = r_resp_valid ? 1 : 0;
                g_grant = r_resp_valid ? int'(r_resp_grant) : int'(l_resp_grant);
                return;
            end
            if (up_req_valid && !sent) begin
                sent = 1;
                g_up_seen = 1;
                g_up_lvl = int'(up_req_level);
                up_resp_valid = 1'b1;
                up_resp_grant = pgrant;
            end
        end
        g_timeout = 1;
    endtask

    task automatic ack_side(int side);
        if (side) begin r_req_valid = 1'b0; r_ack = 1'b1; end
        else      begin l_req_valid = 1'b0; l_ack = 1'b1; end
        @(negedge clk);
        l_ack = 1'b0; r_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_check(string tag, int side, int lvl, bit pgrant);
        int eg;
        eg = (e_kind == 0) ? 1 : (e_kind == 1) ? 0 : int'(pgrant);
        chk(tag, int'(g_timeout), 0, "response timeout");
        chk(tag, g_side, side, "responding side");
        chk(tag, int'(g_up_seen), (e_kind == 2) ? 1 : 0, "parent request raised");
        if (e_kind == 2) begin
            chk(tag, g_up_lvl, e_up, "parent request level");
            chk(tag, int'(g_ack_seen), 1, "parent ack with response");
        end
        chk(tag, g_grant, eg, "grant bit");
        // before ack: nothing committed yet
        chk(tag, side ? int'(right_level) : int'(left_level), side ? m_r : m_l, "level before ack");
        ack_side(side);
        if (eg == 1) begin
            if (side) m_r = lvl; else m_l = lvl;
        end
        chk(tag, int'(left_level), m_l, "left level");
        chk(tag, int'(right_level), m_r, "right level");
        chk("R2", int'(node_level), mean_of(m_l, m_r), "node level");
    endtask

    task automatic raise(int side, int lvl);
        if (side) begin r_req_valid = 1'b1; r_req_level = 3'(lvl); end
        else      begin l_req_valid = 1'b1; l_req_level = 3'(lvl); end
    endtask

    task automatic txn(string tag, int side, int lvl, bit pgrant);
        compute_exp(side, lvl);
        raise(side, lvl);
        serve(pgrant);
        finish_check(tag, side, lvl, pgrant);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", int'(left_level), 0, "left level");
        chk("R1", int'(right_level), 0, "right level");
        chk("R1", int'(node_level), 0, "node level");
        chk("R1", int'(up_req_valid | up_ack | l_resp_valid | r_resp_valid | split_active), 0,
            "outputs idle");

        // R11 right request for High from L:L forwards mean M
        txn("R11", 1, 4, 1'b1);
        // R9 split state
        split_mode_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", int'(split_active), 1, "split indicator");
        chk("R9", int'(node_level), 2, "node level in split");
        txn("R9", 0, 3, 1'b1);
        txn("R7", 0, 4, 1'b1);
        split_mode_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", int'(split_active), 0, "split cleared");
        // R6 parent deny: L:H -> MH:H would give H
        txn("R6", 0, 3, 1'b0);
        // R5 parent grant: left ML gives mean MH
        txn("R5", 0, 1, 1'b1);

        // R8 simultaneous requests: left first, right stalled
        compute_exp(0, 2);
        raise(0, 2);
        raise(1, 1);
        serve(1'b1);
        chk("R8", int'(r_req_valid), 1, "right still waiting");
        finish_check("R8", 0, 2, 1'b1);
        compute_exp(1, 1);
        serve(1'b1);
        finish_check("R8", 1, 1, 1'b1);

        // R3 local grant: M:ML -> MH:ML keeps mean M
        txn("R3", 0, 3, 1'b1);

        // random mix (R3..R7, R11)
        for (int k = 0; k < 80; k++) begin
            int side, lvl;
            bit pg;
            if ($urandom_range(0, 9) == 0) begin
                split_mode_en = ~split_mode_en;
                repeat (3) @(negedge clk);
            end
            side = $urandom_range(0, 1);
            lvl  = $urandom_range(0, 4);
            pg   = 1'($urandom_range(0, 1));
            txn("R4", side, lvl, pg);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule